// File: doc/BRIEF.md
# Lookup-Table Numerically Controlled Oscillator

This block produces a stream of signed cosine samples whose frequency is set by a binary tuning word. On each enabled clock a wide phase register advances by the tuning word and wraps at its own width. The register is read as an unsigned fraction of one cycle, so the output frequency equals the tuning word divided by 2^NP, times the clock rate. Only the upper NA phase bits address the waveform table. The lower bits are dropped without rounding.

The table holds a cosine as an ND-bit two's-complement fraction. Every entry is scaled by a gain a half step below unity, so that the peak of +1 fits without an extra integer bit. The table contents are computed at elaboration. A parameter selects either a full-cycle table or a quarter-cycle table. The quarter-cycle table needs one quarter of the storage. In that mode a small mapping stage mirrors the address and restores the sign, and its output is identical to the full table. The accumulator width, table address width and sample width are independent parameters. The default build uses 27, 10 and 13 bits.

Top module: `lut_nco`

## Requirements
- R1: On every clock edge with `en` high, the phase register becomes (phase + `freq_word`) modulo 2^NP. With `en` low, the phase register keeps its value.
- R2: The table address is the top NA bits of the phase register, taken by truncation, so the lower NP−NA bits never change the address.
- R3: For table address a, `sample` lies within one LSB of (2^(ND−1) − 0.5)·cos(2π·a/2^NA). This is the cosine scaled by 1 − 2^−(ND−1)/2, in units of 2^−(ND−1).
- R4: Address 0 yields exactly +(2^(ND−1) − 1). Address 2^(NA−1) yields exactly −(2^(ND−1) − 1). The code −2^(ND−1) never appears.
- R5: With QUARTER=1, the table stores only 2^(NA−2) words. For every address, the sample equals the full-table sample bit for bit.
- R6: The phase value written at clock edge k is presented on `sample` after edge k+2.
- R7: `sample_valid` is high after edge k+2 exactly when `en` was high at edge k.
- R8: While `rst_n` is low, the phase register, `sample` and `sample_valid` are all zero.
- R9: A new `freq_word` is used at the next enabled edge. It is added to the current phase, with no jump or restart of the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance the phase on this edge |
| freq_word | input | NP | Phase increment per enabled clock |
| sample | output | ND | Signed cosine sample, fraction with ND−1 fraction bits |
| sample_valid | output | 1 | Marks a sample produced from an enabled step |

## Verification
The phase written at an enabled edge is due on `sample` and `sample_valid` after the second edge that follows it. That is one register in the address-mapping stage plus one on the table output. The scoreboard pushes one expected entry on every clock after reset: the enable and the truncated address from its own phase model. The monitor pops an entry only when three are queued, on the falling edge, which lines each expectation up with the output after edge k+2. Two instances, one with the full table and one with the quarter table, receive identical stimulus and are compared on the same falling edge.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Rounded, scaled cosine code for table address addr (na address bits, nd data bits).
  // Gain is 2^(nd-1) - 0.5; the result is clamped symmetrically to +/-(2^(nd-1)-1).
  function automatic int cos_code(input int addr, input int na, input int nd);
    real two_pi;
    real gain;
    real x;
    int  v;
    int  lim;
    two_pi = 6.283185307179586;
    gain   = (2.0 ** (nd - 1)) - 0.5;
    x      = gain * $cos(two_pi * real'(addr) / (2.0 ** na));
    lim    = (1 << (nd - 1)) - 1;
    if (x >= 0.0) v = $rtoi(x + 0.5);
    else          v = -$rtoi(-x + 0.5);
    if (v > lim)  v = lim;
    if (v < -lim) v = -lim;
    return v;
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int NP = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [NP-1:0] freq_word,
  output logic [NP-1:0] phase,
  output logic          step_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= '0;
      step_valid <= 1'b0;
    end else begin
      if (en) phase <= phase + freq_word;
      step_valid <= en;
    end
  end

endmodule

// File: rtl/nco_addr_map.sv
module nco_addr_map #(
  parameter int NA      = 10,
  parameter int QUARTER = 0,
  localparam int IW     = (QUARTER != 0) ? NA - 2 : NA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NA-1:0] addr,
  input  logic          in_valid,
  output logic [IW-1:0] idx,
  output logic          negate,
  output logic          zero_force,
  output logic          out_valid
);

  logic [IW-1:0] idx_n;
  logic          neg_n;
  logic          zero_n;

  generate
    if (QUARTER != 0) begin : g_quarter
      logic [1:0]    quad;
      logic [IW-1:0] low;
      logic [IW-1:0] mirrored;
      assign quad     = addr[NA-1:NA-2];
      assign low      = addr[IW-1:0];
      // Quarter minus low: wraps to zero when low is zero, which marks the zero crossing.
      assign mirrored = ~low + IW'(1);
      always_comb begin
        idx_n  = quad[0] ? mirrored : low;
        neg_n  = quad[0] ^ quad[1];
        zero_n = quad[0] && (low == '0);
      end
    end else begin : g_full
      always_comb begin
        idx_n  = addr;
        neg_n  = 1'b0;
        zero_n = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      negate     <= 1'b0;
      zero_force <= 1'b0;
      out_valid  <= 1'b0;
    end else begin
      idx        <= idx_n;
      negate     <= neg_n;
      zero_force <= zero_n;
      out_valid  <= in_valid;
    end
  end

endmodule

// File: rtl/nco_cos_table.sv
module nco_cos_table #(
  parameter int NA      = 10,
  parameter int ND      = 13,
  parameter int QUARTER = 0,
  localparam int IW     = (QUARTER != 0) ? NA - 2 : NA,
  localparam int DEPTH  = 1 << IW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IW-1:0]        idx,
  input  logic                 negate,
  input  logic                 zero_force,
  input  logic                 in_valid,
  output logic signed [ND-1:0] sample,
  output logic                 out_valid
);

  logic signed [ND-1:0] rom [DEPTH];
  logic signed [ND-1:0] raw;
  logic signed [ND-1:0] val;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
      assign rom[g] = ND'(nco_pkg::cos_code(g, NA, ND));
    end
  endgenerate

  always_comb begin
    raw = rom[idx];
    if (zero_force)  val = '0;
    else if (negate) val = -raw;
    else             val = raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample    <= '0;
      out_valid <= 1'b0;
    end else begin
      sample    <= val;
      out_valid <= in_valid;
    end
  end

endmodule

// File: rtl/lut_nco.sv
module lut_nco #(
  parameter int NP      = 27,
  parameter int NA      = 10,
  parameter int ND      = 13,
  parameter int QUARTER = 0,
  localparam int IW     = (QUARTER != 0) ? NA - 2 : NA
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [NP-1:0]        freq_word,
  output logic signed [ND-1:0] sample,
  output logic                 sample_valid
);

  logic [NP-1:0] acc_phase;
  logic          acc_valid;
  logic [IW-1:0] tbl_idx;
  logic          tbl_neg;
  logic          tbl_zero;
  logic          addr_valid;

  nco_phase_acc #(.NP(NP)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .freq_word  (freq_word),
    .phase      (acc_phase),
    .step_valid (acc_valid)
  );

  nco_addr_map #(.NA(NA), .QUARTER(QUARTER)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (acc_phase[NP-1 -: NA]),
    .in_valid   (acc_valid),
    .idx        (tbl_idx),
    .negate     (tbl_neg),
    .zero_force (tbl_zero),
    .out_valid  (addr_valid)
  );

  nco_cos_table #(.NA(NA), .ND(ND), .QUARTER(QUARTER)) u_tbl (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (tbl_idx),
    .negate     (tbl_neg),
    .zero_force (tbl_zero),
    .in_valid   (addr_valid),
    .sample     (sample),
    .out_valid  (sample_valid)
  );

endmodule

// File: rtl/lut_nco_chk.sv
module lut_nco_chk #(
  parameter int NP = 27,
  parameter int ND = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic [NP-1:0]        freq_word,
  input logic [NP-1:0]        acc_phase,
  input logic                 acc_valid,
  input logic                 addr_valid,
  input logic signed [ND-1:0] sample,
  input logic                 sample_valid
);

  // R1
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (acc_phase == NP'($past(acc_phase) + $past(freq_word))));

  // R1
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_phase));

  // R7
  valid_stage1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> acc_valid);

  // R7
  valid_stage2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> addr_valid);

  // R7
  valid_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid == $past(addr_valid) |=> sample_valid == $past(addr_valid));

  // R4
  no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample != {1'b1, {(ND-1){1'b0}}});

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (acc_phase == '0 && !sample_valid && sample == '0));

endmodule

bind lut_nco lut_nco_chk #(.NP(NP), .ND(ND)) u_lut_nco_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .freq_word    (freq_word),
  .acc_phase    (acc_phase),
  .acc_valid    (acc_valid),
  .addr_valid   (addr_valid),
  .sample       (sample),
  .sample_valid (sample_valid)
);

// File: tb/lut_nco_bench.sv
`timescale 1ns/1ps
module lut_nco_bench;

  localparam int NP  = 27;
  localparam int NA  = 10;
  localparam int ND  = 13;
  localparam int LIM = (1 << (ND - 1)) - 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 en = 1'b0;
  logic [NP-1:0]        fw = '0;
  logic signed [ND-1:0] s_full;
  logic signed [ND-1:0] s_qw;
  logic                 v_full;
  logic                 v_qw;

  always #2 clk = ~clk;

  lut_nco #(.NP(NP), .NA(NA), .ND(ND), .QUARTER(0)) u_lut_nco (
    .clk(clk), .rst_n(rst_n), .en(en), .freq_word(fw),
    .sample(s_full), .sample_valid(v_full));

  lut_nco #(.NP(NP), .NA(NA), .ND(ND), .QUARTER(1)) u_lut_nco_qw (
    .clk(clk), .rst_n(rst_n), .en(en), .freq_word(fw),
    .sample(s_qw), .sample_valid(v_qw));

  typedef struct { bit vld; int addr; } exp_t;
  exp_t          sb[$];
  logic [NP-1:0] m_acc;
  int            checks = 0;
  int            fails = 0;
  bit            reported = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Driver-side model: phase per R1/R9, truncated address per R2, pushed once per clock.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = '0;
      sb.delete();
    end else begin
      if (en) m_acc = m_acc + fw;
      sb.push_back('{vld: en, addr: int'(m_acc[NP-1 -: NA])});
    end
  end

  // Monitor: entry from edge k compared after edge k+2 (R6).
  always @(negedge clk) begin
    if (rst_n && sb.size() >= 3) begin
      exp_t e;
      real  ideal;
      real  diff;
      e = sb.pop_front();
      check(v_full == e.vld, "R7 valid", int'(v_full), int'(e.vld));
      check(v_qw == e.vld, "R7 valid quarter", int'(v_qw), int'(e.vld));
      if (e.vld) begin
        ideal = ((2.0 ** (ND - 1)) - 0.5) * $cos(6.283185307179586 * real'(e.addr) / (2.0 ** NA));
        diff  = real'(s_full) - ideal;
        if (diff < 0.0) diff = -diff;
        // R3 cosine value; also exercises R1, R2, R6 and R9 through the model address
        check(diff <= 1.0, "R3 cosine", int'(s_full), $rtoi(ideal));
        check(s_qw == s_full, "R5 quarter equals full", int'(s_qw), int'(s_full));
        if (e.addr == 0)
          check(s_full == LIM, "R4 positive peak", int'(s_full), LIM);
        if (e.addr == (1 << (NA - 1)))
          check(s_full == -LIM, "R4 negative peak", int'(s_full), -LIM);
      end
    end
  end

  task automatic run(input logic [NP-1:0] word, input int n);
    @(negedge clk);
    fw = word;
    en = 1'b1;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(s_full == 0, "R8 reset sample", int'(s_full), 0);
    check(v_full == 0, "R8 reset valid", int'(v_full), 0);
    check(s_qw == 0, "R8 reset sample quarter", int'(s_qw), 0);
    rst_n = 1'b1;

    run('0, 6);                               // R4: phase stays at address 0
    run(NP'(1) << (NP - 2), 12);              // quadrant edges, R5 zero crossings
    run(NP'(1) << (NP - 1), 8);               // R4: alternating peaks
    run(NP'(27'h0123457), 400);               // general tone
    run(NP'(27'h2F0A1C3), 300);               // R9: word change mid-run
    run({NP{1'b1}}, 300);                     // R1: wrap, backwards rotation
    run((NP'(1) << (NP - NA)) - NP'(1), 200); // R2: truncation of low bits
    // R1 hold: enable low while the word changes, then resume
    @(negedge clk);
    en = 1'b0;
    fw = NP'(27'h1555555);
    repeat (10) @(negedge clk);
    run(NP'(27'h00ABCDE), 150);
    // R8 mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    check(s_full == 0, "R8 mid-run reset sample", int'(s_full), 0);
    check(v_full == 0, "R8 mid-run reset valid", int'(v_full), 0);
    rst_n = 1'b1;
    run(NP'(27'h0333333), 120);
    @(negedge clk);
    en = 1'b0;
    repeat (6) @(negedge clk);
    report();
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    report();
  end

endmodule